// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block merges several reset requests into a single system reset and keeps a byte of cause flags that software can read and write. Three supply brown-out indications, a software reset strobe, a stack-error pulse and an external reset pin can each request a reset. A configuration enable gates the main-supply, battery, deep-sleep and stack sources. The core-supply source has no enable.

Supply-type requests hold the reset for as long as they are present. After they go away, a power-up timer keeps the reset asserted for a programmable number of cycles. The software strobe and the stack error give a one-cycle reset pulse that leaves the timer alone. The external pin is synchronised, and then it has to stay low for a fixed number of consecutive samples before it counts as a request. A deep-sleep brown-out never resets the device: it only sets a sticky flag. A battery-mode output records a battery brown-out and stays set until the main supply is reported good again.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `bat_mode` is 0 and `flags` is 8'h24. Flag bits: [0] core brown-out, [1] power-on, [2] main brown-out, [3] battery brown-out, [4] deep-sleep brown-out, [5] reset instruction, [6] stack error, [7] external pin. After `por_n` rises, `sys_rst` falls after the (P+2)-th rising edge, where P is `pwrt_period`.
- R2: `core_bo` high at an edge holds `sys_rst` high from that edge. `sys_rst` falls only after the (P+1)-th edge following the last edge at which `core_bo` was sampled high. Each such edge clears flag bit 0.
- R3: `main_bo` has the R2 hold behaviour and sets flag bit 2, but only when `en_main_bo` is 1. Otherwise it has no effect.
- R4: When `en_bat_bo` is 1, `bat_bo` has the R2 hold behaviour, sets flag bit 3, and sets `bat_mode` if `vdd_good` is 0. When `en_bat_bo` is 0, `bat_bo` changes neither `sys_rst`, the flags nor `bat_mode`.
- R5: `bat_mode` stays 1 through and after the reset. It clears on the edge after `vdd_good` is sampled 1.
- R6: `ds_bo` with `en_ds_bo` and `deep_sleep` both 1 sets flag bit 4 on the next edge. The bit stays set until software writes it. `ds_bo` never asserts `sys_rst`.
- R7: `sw_rst` high at an edge makes `sys_rst` 1 for exactly the following cycle and clears flag bit 5. It neither reloads nor stops a running power-up timer.
- R8: `stk_err` with `en_stk` 1 gives the same one-cycle reset as R7 and sets flag bit 6. With `en_stk` 0 it has no effect.
- R9: `ext_rst_n` low at four consecutive edges n-6..n-3 is a hold request at edge n and sets flag bit 7. A shorter low pulse is discarded.
- R10: `flag_we` loads `flag_wdata` into `flags` on the next edge only while `sys_rst` is 0. In the same cycle, a flag event overrides the written value of its bit.
- R11: With P = 0, `sys_rst` falls after the first edge at which no hold request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| core_bo | input | 1 | Core-supply brown-out level |
| main_bo | input | 1 | Main-supply brown-out level |
| bat_bo | input | 1 | Battery-supply brown-out level |
| ds_bo | input | 1 | Deep-sleep brown-out level |
| sw_rst | input | 1 | Software reset strobe |
| stk_err | input | 1 | Stack-error pulse |
| ext_rst_n | input | 1 | Raw external reset pin, active low |
| deep_sleep | input | 1 | Device is in deep sleep |
| vdd_good | input | 1 | Main supply present |
| en_main_bo | input | 1 | Enable for the main-supply brown-out source |
| en_bat_bo | input | 1 | Enable for the battery brown-out source |
| en_ds_bo | input | 1 | Enable for the deep-sleep brown-out source |
| en_stk | input | 1 | Enable for the stack-error reset |
| pwrt_period | input | PW | Power-up timer length P in cycles |
| flag_we | input | 1 | Software flag write strobe |
| flag_wdata | input | 8 | Software flag write value |
| sys_rst | output | 1 | System reset, active high |
| bat_mode | output | 1 | Battery-mode indication |
| flags | output | 8 | Reset cause flags |

## Verification
Each result becomes visible after a known number of edges. Flags, `bat_mode` and the one-cycle pulses appear after the first edge at which their cause is sampled. Timer-held resets stay up through edge h+P, where h is the last edge that saw a hold request. The pin filter responds to samples taken three to six edges earlier. The bench's reference model keeps the index h of that last hold edge and the P captured there, and it keeps a short history of pin samples. From these it predicts every output for each edge. Outputs are compared 1 ns after every rising edge, once the edge has settled and before the inputs next change at the falling edge.

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
  parameter int PW       = 8,
  parameter int FILT_LEN = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          core_bo,
  input  logic          main_bo,
  input  logic          bat_bo,
  input  logic          ds_bo,
  input  logic          sw_rst,
  input  logic          stk_err,
  input  logic          ext_rst_n,
  input  logic          deep_sleep,
  input  logic          vdd_good,
  input  logic          en_main_bo,
  input  logic          en_bat_bo,
  input  logic          en_ds_bo,
  input  logic          en_stk,
  input  logic [PW-1:0] pwrt_period,
  input  logic          flag_we,
  input  logic [7:0]    flag_wdata,
  output logic          sys_rst,
  output logic          bat_mode,
  output logic [7:0]    flags
);

  localparam int LW = $clog2(FILT_LEN + 1);
  localparam logic [7:0] FLAG_INIT = 8'h24;

  logic [1:0]    ext_sync;
  logic [LW-1:0] low_run;
  logic          ext_hold;
  logic          power_ld;
  logic          busy;
  logic          pulse_q;
  logic [PW-1:0] cnt;
  logic          hold;
  logic          main_ev, bat_ev, ds_ev, stk_ev;
  logic [7:0]    set_m, clr_m, base, nxt;

  assign ext_hold = (low_run == LW'(FILT_LEN));
  assign main_ev  = en_main_bo & main_bo;
  assign bat_ev   = en_bat_bo & bat_bo;
  assign ds_ev    = en_ds_bo & ds_bo & deep_sleep;
  assign stk_ev   = en_stk & stk_err;
  assign hold     = power_ld | core_bo | main_ev | bat_ev | ext_hold;
  assign sys_rst  = busy | pulse_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ext_sync <= 2'b11;
      low_run  <= '0;
    end else begin
      ext_sync <= {ext_sync[0], ext_rst_n};
      if (ext_sync[1])   low_run <= '0;
      else if (!ext_hold) low_run <= low_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      power_ld <= 1'b1;
      busy     <= 1'b1;
      cnt      <= '0;
      pulse_q  <= 1'b0;
    end else begin
      power_ld <= 1'b0;
      pulse_q  <= sw_rst | stk_ev;
      if (hold) begin
        busy <= 1'b1;
        cnt  <= pwrt_period;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign set_m = {ext_hold, stk_ev, 1'b0, ds_ev, bat_ev, main_ev, 2'b00};
  assign clr_m = {2'b00, sw_rst, 4'b0000, core_bo};
  assign base  = (flag_we && !sys_rst) ? flag_wdata : flags;
  assign nxt   = (base | set_m) & ~clr_m;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags    <= FLAG_INIT;
      bat_mode <= 1'b0;
    end else begin
      flags <= nxt;
      if (vdd_good)    bat_mode <= 1'b0;
      else if (bat_ev) bat_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sw_rst,
  input logic       core_bo,
  input logic       main_bo,
  input logic       en_main_bo,
  input logic       ds_bo,
  input logic       en_ds_bo,
  input logic       deep_sleep,
  input logic       vdd_good,
  input logic       sys_rst,
  input logic       bat_mode,
  input logic [7:0] flags
);

  // R7
  sw_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> sys_rst);

  // R7
  ri_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> !flags[5]);

  // R2
  core_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_bo |=> (sys_rst && !flags[0]));

  // R3
  main_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    (en_main_bo && main_bo) |=> (sys_rst && flags[2]));

  // R6
  ds_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (en_ds_bo && ds_bo && deep_sleep) |=> flags[4]);

  // R5
  vdd_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    vdd_good |=> !bat_mode);

endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .core_bo(core_bo),
  .main_bo(main_bo), .en_main_bo(en_main_bo), .ds_bo(ds_bo),
  .en_ds_bo(en_ds_bo), .deep_sleep(deep_sleep), .vdd_good(vdd_good),
  .sys_rst(sys_rst), .bat_mode(bat_mode), .flags(flags)
);

// File: tb/tb_reset_cause_ctrl.sv
`timescale 1ns/1ps
module tb_reset_cause_ctrl;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic core_bo = 0, main_bo = 0, bat_bo = 0, ds_bo = 0;
  logic sw_rst = 0, stk_err = 0, ext_rst_n = 1, deep_sleep = 0, vdd_good = 1;
  logic en_main_bo = 0, en_bat_bo = 0, en_ds_bo = 0, en_stk = 0;
  logic [PW-1:0] pwrt_period = 8'd3;
  logic flag_we = 0;
  logic [7:0] flag_wdata = 8'h00;
  logic sys_rst, bat_mode;
  logic [7:0] flags;

  always #2.5 clk = ~clk;

  reset_cause_ctrl #(.PW(PW), .FILT_LEN(4)) dut (
    .clk(clk), .por_n(por_n), .core_bo(core_bo), .main_bo(main_bo),
    .bat_bo(bat_bo), .ds_bo(ds_bo), .sw_rst(sw_rst), .stk_err(stk_err),
    .ext_rst_n(ext_rst_n), .deep_sleep(deep_sleep), .vdd_good(vdd_good),
    .en_main_bo(en_main_bo), .en_bat_bo(en_bat_bo), .en_ds_bo(en_ds_bo),
    .en_stk(en_stk), .pwrt_period(pwrt_period), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .sys_rst(sys_rst), .bat_mode(bat_mode),
    .flags(flags)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  int  n, last_h, hold_p;
  bit  ld, m_rst, m_bat;
  bit [7:0] m_flags, pin_hist;

  always @(posedge clk) begin
    bit hold, eh;
    if (!por_n) begin
      n = 0; last_h = -1000; hold_p = 0; ld = 1;
      m_rst = 1; m_bat = 0; m_flags = 8'h24; pin_hist = 8'hFF;
    end else begin
      eh = (pin_hist[5:2] == 4'b0000);
      hold = ld | core_bo | (en_main_bo & main_bo) | (en_bat_bo & bat_bo) | eh;
      if (hold) begin last_h = n; hold_p = int'(pwrt_period); end
      ld = 0;
      if (flag_we && !m_rst) m_flags = flag_wdata;
      if (core_bo) m_flags[0] = 0;
      if (en_main_bo && main_bo) m_flags[2] = 1;
      if (en_bat_bo && bat_bo) m_flags[3] = 1;
      if (en_ds_bo && ds_bo && deep_sleep) m_flags[4] = 1;
      if (sw_rst) m_flags[5] = 0;
      if (en_stk && stk_err) m_flags[6] = 1;
      if (eh) m_flags[7] = 1;
      if (vdd_good) m_bat = 0;
      else if (en_bat_bo && bat_bo) m_bat = 1;
      m_rst = (n <= last_h + hold_p) || sw_rst || (en_stk && stk_err);
      pin_hist = {pin_hist[6:0], ext_rst_n};
      n++;
    end
    #1;
    checks++;
    if (sys_rst !== m_rst || bat_mode !== m_bat || flags !== m_flags) begin
      fails++;
      $display("FAIL %s: rst/bat/flags actual %b/%b/%h expected %b/%b/%h",
               phase, sys_rst, bat_mode, flags, m_rst, m_bat, m_flags);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse1(ref logic s, input int len);
    @(negedge clk); s = 1; step(len); s = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); flag_we = 1; flag_wdata = v;
    @(negedge clk); flag_we = 0;
  endtask

  initial begin
    step(3); por_n = 1;
    phase = "R1"; step(8);
    phase = "R10"; wr(8'hFF); step(2);
    @(negedge clk); core_bo = 1; @(negedge clk); core_bo = 0;
    flag_we = 1; flag_wdata = 8'h00; step(2); flag_we = 0; step(6);
    @(negedge clk); sw_rst = 1; flag_we = 1; flag_wdata = 8'hFF;
    @(negedge clk); sw_rst = 0; flag_we = 0; step(3);
    wr(8'h00); step(2);
    phase = "R2"; pulse1(core_bo, 2); step(8);
    phase = "R3"; pulse1(main_bo, 2); step(3);
    en_main_bo = 1; pulse1(main_bo, 2); step(8); en_main_bo = 0;
    phase = "R4"; vdd_good = 0; pulse1(bat_bo, 2); step(3);
    en_bat_bo = 1; pulse1(bat_bo, 2); step(8);
    phase = "R5"; step(3); vdd_good = 1; step(3); en_bat_bo = 0;
    phase = "R6"; deep_sleep = 1; pulse1(ds_bo, 1); step(2);
    en_ds_bo = 1; pulse1(ds_bo, 1); step(5); deep_sleep = 0; en_ds_bo = 0;
    phase = "R7"; pulse1(sw_rst, 1); step(3);
    @(negedge clk); core_bo = 1; @(negedge clk); core_bo = 0;
    step(1); pulse1(sw_rst, 1); step(8);
    phase = "R8"; pulse1(stk_err, 1); step(3);
    en_stk = 1; pulse1(stk_err, 1); step(3); en_stk = 0;
    phase = "R9"; pulse1(ext_rst_n, 0);
    @(negedge clk); ext_rst_n = 0; step(3); ext_rst_n = 1; step(10);
    @(negedge clk); ext_rst_n = 0; step(4); ext_rst_n = 1; step(14);
    @(negedge clk); ext_rst_n = 0; step(10); ext_rst_n = 1; step(14);
    phase = "R11"; pwrt_period = 8'd0; pulse1(core_bo, 1); step(4);
    pulse1(sw_rst, 1); step(3);
    pwrt_period = 8'd5; pulse1(main_bo, 1); en_main_bo = 1; pulse1(main_bo, 3);
    en_main_bo = 0; step(12);
    phase = "R10"; wr(8'h5A); step(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule